// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block sits between a group of chip pads and the on-chip peripherals that normally own them. Each pin has its own routing choice. It either stays under peripheral control or is taken over by a general-purpose I/O function. In peripheral mode the peripheral decides whether the pad drives and what it drives, and it sees the pad's input directly. In GPIO mode a direction bit and a data bit held in the block take over the pad. The peripheral then sees a constant high input, and its own drive requests are ignored.

Software reaches four word-addressed registers through a plain write strobe with a combinational read port. The registers are routing select, direction, data and pull-up request. Each pad gets a pull-up request that is qualified so that it is never active while the pad drives. Reading the data register returns the synchronized pad level for input pins and the stored value for output pins. The pin count is a parameter. Register bits above the pin count read back as fixed constants: 1 in the routing and pull-up registers, 0 in the direction and data registers.

Top module: `gpio_port_mux`

## Requirements
- R1: With a pin's routing bit at 1 (peripheral mode), pad_oe and pad_out of that pin follow periph_oe and periph_dout, and periph_din follows pad_in combinationally.
- R2: With a pin's routing bit at 0 (GPIO mode), pad_oe of that pin equals its direction bit (1 = output), and when it drives, pad_out equals its data register bit.
- R3: In GPIO mode periph_din of that pin is 1 whatever the pad level, and periph_oe and periph_dout of that pin have no effect on pad_oe or pad_out.
- R4: pad_pu of a pin is its pull-up register bit when the pin is not driving, and is 0 whenever pad_oe of that pin is 1, in either mode.
- R5: reg_addr selects 0 = routing, 1 = direction, 2 = data, 3 = pull-up. A write with reg_wr high stores reg_wdata[NUM_PINS-1:0] at the next rising clock edge, and nothing changes while reg_wr is low.
- R6: reg_rdata bits at and above NUM_PINS read 1 at offsets 0 and 3 and read 0 at offsets 1 and 2, regardless of what was written.
- R7: After reset, every routing bit is 1, direction is all input (0), data is 0, and every pull-up request is 1.
- R8: For a pin whose direction bit is 0, the data offset returns pad_in through two clock stages. A pad change made between edges is visible after the second following rising edge and not after the first.
- R9: For a pin whose direction bit is 1, the data offset returns the stored data bit and not the pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| periph_oe | input | NUM_PINS | Peripheral drive request per pin |
| periph_dout | input | NUM_PINS | Peripheral output level per pin |
| periph_din | output | NUM_PINS | Pad level returned to the peripheral (high in GPIO mode) |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_out | output | NUM_PINS | Level driven to each pad |
| pad_oe | output | NUM_PINS | Drive enable for each pad |
| pad_pu | output | NUM_PINS | Qualified pull-up enable for each pad |

## Verification
The bench targets the pull-up qualification. A design that forgot to gate the pull-up with drive would leave resistors fighting driven pins, and the bench exposes this by comparing pad_pu against pins driven by both the peripheral and the direction register. It flips the peripheral's drive inputs while pins are in GPIO mode, which catches a mux that leaks peripheral control or lets the peripheral see the real pad instead of a constant high. It probes readback above the pin count at all four offsets, where swapped fill constants would show as wrong upper bits. It times a pad change edge by edge, so a synchronizer with one stage or three would show the new level one cycle early or late. A mixed-direction read of the data offset catches a design that always returns the pad or always returns the stored bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    OFS_ROUTE = 2'd0,
    OFS_DIR   = 2'd1,
    OFS_DATA  = 2'd2,
    OFS_PULL  = 2'd3
  } reg_ofs_e;

  // pull-up may only act on a pad that is not being driven
  function automatic logic pull_qualify(input logic pull_req, input logic driving);
    return pull_req & ~driving;
  endfunction

  // fill value for readback bits above the implemented pins
  function automatic logic upper_fill(input reg_ofs_e ofs);
    return (ofs == OFS_ROUTE) || (ofs == OFS_PULL);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_raw,
  output logic [NUM_PINS-1:0] pad_sync
);

  logic [NUM_PINS-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      pad_sync <= '0;
    end else begin
      stage1   <= pad_raw;
      pad_sync <= stage1;
    end
  end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] pad_sync,
  output logic [NUM_PINS-1:0] route_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] dat_q,
  output logic [NUM_PINS-1:0] pull_q,
  output logic [DATA_W-1:0]   rdata
);

  localparam int HI_W = DATA_W - NUM_PINS;

  // output pins read back the stored bit, input pins the synchronized pad
  function automatic logic [NUM_PINS-1:0] data_view(
    input logic [NUM_PINS-1:0] dir,
    input logic [NUM_PINS-1:0] stored,
    input logic [NUM_PINS-1:0] pad);
    return (dir & stored) | (~dir & pad);
  endfunction

  logic [NUM_PINS-1:0] wbits;
  logic                wr_route, wr_dir, wr_dat, wr_pull;
  reg_ofs_e            ofs;

  assign ofs      = reg_ofs_e'(addr);
  assign wbits    = wdata[NUM_PINS-1:0];
  assign wr_route = wr && (ofs == OFS_ROUTE);
  assign wr_dir   = wr && (ofs == OFS_DIR);
  assign wr_dat   = wr && (ofs == OFS_DATA);
  assign wr_pull  = wr && (ofs == OFS_PULL);

  generate
    if (HI_W > 0) begin : g_hi
      logic wdata_hi_unused;
      assign wdata_hi_unused = ^wdata[DATA_W-1:NUM_PINS];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '1;
      dir_q   <= '0;
      dat_q   <= '0;
      pull_q  <= '1;
    end else begin
      if (wr_route) route_q <= wbits;
      if (wr_dir)   dir_q   <= wbits;
      if (wr_dat)   dat_q   <= wbits;
      if (wr_pull)  pull_q  <= wbits;
    end
  end

  always_comb begin
    rdata = upper_fill(ofs) ? '1 : '0;
    unique case (ofs)
      OFS_ROUTE: rdata[NUM_PINS-1:0] = route_q;
      OFS_DIR:   rdata[NUM_PINS-1:0] = dir_q;
      OFS_DATA:  rdata[NUM_PINS-1:0] = data_view(dir_q, dat_q, pad_sync);
      OFS_PULL:  rdata[NUM_PINS-1:0] = pull_q;
      default:   rdata[NUM_PINS-1:0] = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_port_pkg::*;
(
  input  logic periph_sel,
  input  logic gpio_dir,
  input  logic gpio_dat,
  input  logic pull_req,
  input  logic periph_oe,
  input  logic periph_dout,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_out,
  output logic pad_pu,
  output logic periph_din
);

  always_comb begin
    if (periph_sel) begin
      pad_oe     = periph_oe;
      pad_out    = periph_dout;
      periph_din = pad_in;
    end else begin
      pad_oe     = gpio_dir;
      pad_out    = gpio_dat;
      periph_din = 1'b1;
    end
    pad_pu = pull_qualify(pull_req, pad_oe);
  end

endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] periph_oe,
  input  logic [NUM_PINS-1:0] periph_dout,
  output logic [NUM_PINS-1:0] periph_din,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu
);

  // named internal state, brought out for the checker
  logic [NUM_PINS-1:0] route_w;
  logic [NUM_PINS-1:0] dir_w;
  logic [NUM_PINS-1:0] dat_w;
  logic [NUM_PINS-1:0] pull_w;
  logic [NUM_PINS-1:0] pad_sync_w;

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_raw  (pad_in),
    .pad_sync (pad_sync_w)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .pad_sync (pad_sync_w),
    .route_q  (route_w),
    .dir_q    (dir_w),
    .dat_q    (dat_w),
    .pull_q   (pull_w),
    .rdata    (reg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_pin_slice u_slice (
        .periph_sel  (route_w[i]),
        .gpio_dir    (dir_w[i]),
        .gpio_dat    (dat_w[i]),
        .pull_req    (pull_w[i]),
        .periph_oe   (periph_oe[i]),
        .periph_dout (periph_dout[i]),
        .pad_in      (pad_in[i]),
        .pad_oe      (pad_oe[i]),
        .pad_out     (pad_out[i]),
        .pad_pu      (pad_pu[i]),
        .periph_din  (periph_din[i])
      );
    end
  endgenerate

endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk #(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [1:0]          reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_PINS-1:0] periph_oe,
  input logic [NUM_PINS-1:0] periph_dout,
  input logic [NUM_PINS-1:0] periph_din,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_pu,
  input logic [NUM_PINS-1:0] route_w,
  input logic [NUM_PINS-1:0] dir_w,
  input logic [NUM_PINS-1:0] dat_w,
  input logic [NUM_PINS-1:0] pull_w,
  input logic [NUM_PINS-1:0] pad_sync_w
);

  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((64'd1 << NUM_PINS) - 64'd1);
  localparam logic [DATA_W-1:0] HI_MASK  = ~LOW_MASK;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  a_r1_periph_route: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & route_w) == (periph_oe & route_w)) &&
    ((pad_out & route_w) == (periph_dout & route_w)) &&
    ((periph_din & route_w) == (pad_in & route_w)));

  a_r2_gpio_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~route_w) == (dir_w & ~route_w)) &&
    ((pad_out & pad_oe & ~route_w) == (dat_w & dir_w & ~route_w)));

  a_r3_periph_sees_high: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_din | route_w) == {NUM_PINS{1'b1}});

  a_r4_no_pull_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) == '0) && ((pad_pu & ~pad_oe) == (pull_w & ~pad_oe)));

  a_r5_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (dir_w == $past(reg_wdata[NUM_PINS-1:0])));

  a_r5_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> ($stable(route_w) && $stable(dir_w) && $stable(dat_w) && $stable(pull_w)));

  a_r6_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0 || reg_addr == 2'd3) |-> ((reg_rdata & HI_MASK) == HI_MASK));

  a_r6_upper_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1 || reg_addr == 2'd2) |-> ((reg_rdata & HI_MASK) == '0));

  a_r8_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (pad_sync_w == $past(pad_in, 2)));

endmodule

bind gpio_port_mux gpio_port_mux_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .periph_oe   (periph_oe),
  .periph_dout (periph_dout),
  .periph_din  (periph_din),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_pu      (pad_pu),
  .route_w     (route_w),
  .dir_w       (dir_w),
  .dat_w       (dat_w),
  .pull_w      (pull_w),
  .pad_sync_w  (pad_sync_w)
);

// File: tb/gpio_port_mux_test.sv
`timescale 1ns/1ps
module gpio_port_mux_test;

  localparam int NP = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NP-1:0] periph_oe = '0, periph_dout = '0, pad_in = '0;
  logic [NP-1:0] periph_din, pad_out, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_mux #(.NUM_PINS(NP), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_oe(periph_oe),
    .periph_dout(periph_dout), .periph_din(periph_din), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic test_reset();
    logic [DW-1:0] v;
    reg_read(2'd0, v); check("R7 route reset", 32'(v), 32'hFFFF);
    reg_read(2'd1, v); check("R7 dir reset", 32'(v), 32'h0000);
    reg_read(2'd2, v); check("R7 data reset", 32'(v), 32'h0000);
    reg_read(2'd3, v); check("R7 pull reset", 32'(v), 32'hFFFF);
    check("R7 pull-ups active at reset", 32'(pad_pu), 32'h3F);
  endtask

  task automatic test_periph_route();
    @(negedge clk);
    periph_oe = 6'b101010; periph_dout = 6'b110011; pad_in = 6'b011001;
    #1;
    check("R1 pad_oe", 32'(pad_oe), 32'h2A);
    check("R1 pad_out", 32'(pad_out), 32'h33);
    check("R1 periph_din", 32'(periph_din), 32'h19);
    check("R4 pull off on periph-driven pins", 32'(pad_pu), 32'h15);
  endtask

  task automatic test_gpio_mode();
    reg_write(2'd0, 16'h0000);
    reg_write(2'd1, 16'h000F);
    reg_write(2'd2, 16'h0005);
    #1;
    check("R2 pad_oe from dir", 32'(pad_oe), 32'h0F);
    check("R2 pad_out driven bits", 32'(pad_out & pad_oe), 32'h05);
    check("R3 periph_din high", 32'(periph_din), 32'h3F);
    check("R4 pull off on gpio-driven pins", 32'(pad_pu), 32'h30);
    @(negedge clk);
    periph_oe = ~periph_oe; periph_dout = ~periph_dout; pad_in = ~pad_in;
    #1;
    check("R3 periph_oe ignored", 32'(pad_oe), 32'h0F);
    check("R3 periph_dout ignored", 32'(pad_out & pad_oe), 32'h05);
    check("R3 periph_din stays high", 32'(periph_din), 32'h3F);
  endtask

  task automatic test_mixed_route();
    reg_write(2'd0, 16'h0030);
    @(negedge clk);
    periph_oe = 6'b010000; periph_dout = 6'b010000; pad_in = 6'b100000;
    #1;
    check("R1 R2 mixed pad_oe", 32'(pad_oe), 32'h1F);
    check("R3 mixed periph_din", 32'(periph_din), 32'h2F);
    check("R4 mixed pad_pu", 32'(pad_pu), 32'h20);
  endtask

  task automatic test_write_strobe();
    logic [DW-1:0] v;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd3; reg_wdata = 16'h0000;
    @(negedge clk); @(negedge clk);
    reg_read(2'd3, v);
    check("R5 no write without strobe", 32'(v), 32'hFFFF);
    reg_write(2'd3, 16'h0013);
    reg_read(2'd3, v);
    check("R5 R6 pull write and upper ones", 32'(v), 32'hFFD3);
  endtask

  task automatic test_upper_bits();
    logic [DW-1:0] v;
    reg_write(2'd0, 16'hAAAA);
    reg_read(2'd0, v);
    check("R6 route upper ones", 32'(v), 32'hFFEA);
    reg_write(2'd1, 16'h5555);
    reg_read(2'd1, v);
    check("R6 dir upper zeros", 32'(v), 32'h0015);
    reg_write(2'd1, 16'hFFFF);
    reg_write(2'd2, 16'hFFFF);
    reg_read(2'd2, v);
    check("R6 R9 data upper zeros", 32'(v), 32'h003F);
  endtask

  task automatic test_sync_latency();
    reg_write(2'd0, 16'h0000);
    reg_write(2'd1, 16'h0000);
    @(negedge clk);
    pad_in = 6'b000000;
    repeat (3) @(negedge clk);
    reg_addr = 2'd2; pad_in = 6'b100110;
    @(posedge clk); #1;
    check("R8 not visible after one edge", 32'(reg_rdata), 32'h0000);
    @(posedge clk); #1;
    check("R8 visible after two edges", 32'(reg_rdata), 32'h0026);
  endtask

  task automatic test_mixed_readback();
    logic [DW-1:0] v;
    reg_write(2'd1, 16'h0038);
    reg_write(2'd2, 16'h002A);
    @(negedge clk);
    pad_in = 6'b010101;
    repeat (3) @(negedge clk);
    reg_read(2'd2, v);
    check("R9 R8 mixed data read", 32'(v), 32'h002D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_periph_route();
    test_gpio_mode();
    test_mixed_route();
    test_write_strobe();
    test_upper_bits();
    test_sync_latency();
    test_mixed_readback();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule